// File: doc/BRIEF.md
# Cascaded Interrupt Priority and End-of-Interrupt Core

This block holds the request and in-service state of a two-stage interrupt controller with sixteen request lines. A primary unit serves lines 0 to 7. A secondary unit serves lines 8 to 15 and reports upward through primary input 2. Each unit latches request strobes and applies a mask supplied from outside. A fixed-priority picker selects the lowest-numbered unmasked request. The block presents a pending flag and an 8-bit vector to the processor side. The vector is the owning unit's base value plus the index of the winning input.

An acknowledge strobe commits the current winner. The winner's request bit clears and its in-service bit sets. End-of-interrupt commands are written as command bytes, one write strobe per unit. A decoder sorts each written byte into one of four kinds:
- `CMD_IDLE`: nothing written.
- `CMD_EOI_NAMED`: clear the in-service bit named by the level field.
- `CMD_EOI_LOWEST`: clear the lowest in-service bit that is set.
- `CMD_OTHER`: any other command, which changes nothing.

The in-service register moves from a bit being set (on acknowledge) to that bit being cleared (on a named or lowest-first command). Each request bit moves from set (on strobe) to cleared (on acknowledge), unless a fresh strobe arrives in the same cycle.

Top module: `irq_pair_core`

## Requirements
- R1: After reset, all request and in-service bits of both units are 0 and `int_pending` is 0.
- R2: A 1 on `req_strobe[n]` for one cycle sets request bit n. Lines 0–7 set primary bits and lines 8–15 set secondary bits n-8. The bit stays set until it is acknowledged, and several lines may strobe together.
- R3: `int_pending` is 1 exactly when (primary requests AND NOT `mask_prim`) is nonzero. Masking never clears a latched request bit.
- R4: Among unmasked primary requests the lowest index wins. The vector is `base_prim` plus that index, modulo 256.
- R5: When `ack` is 1 and `int_pending` is 1, the winner's request bit clears and its in-service bit sets on the next clock edge. When `ack` is 1 and `int_pending` is 0, nothing changes.
- R6: Any strobe on lines 8–15 also sets primary request bit 2. When primary input 2 wins and the secondary unit has an unmasked request, the vector is `base_sec` plus the lowest unmasked secondary index. An acknowledge in that case commits the winner in both units.
- R7: A command byte is decoded as follows: bits 2:0 hold the level, bit 5 is the EOI flag, bit 6 is the select flag and bit 7 is the rotate flag. With EOI=1, rotate=0 and select=1, the command clears only the in-service bit named by the level, in the unit whose write strobe is high.
- R8: With EOI=1, rotate=0 and select=0, the command clears the lowest-numbered set in-service bit and no other.
- R9: Every other command byte (EOI=0, or rotate=1) leaves the in-service register unchanged.
- R10: A strobe on a line in the same cycle that the acknowledge clears that line's request bit leaves the bit set.
- R11: When primary input 2 wins and the secondary unit has no unmasked request, the vector is `base_prim` + 2 and only the primary unit commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_strobe | input | 16 | One-cycle request strobes, lines 0–15 |
| mask_prim | input | 8 | Primary mask, 1 blocks the input |
| mask_sec | input | 8 | Secondary mask, 1 blocks the input |
| base_prim | input | 8 | Primary vector base |
| base_sec | input | 8 | Secondary vector base |
| ack | input | 1 | Acknowledge strobe |
| cmd_prim_wr | input | 1 | Command write to the primary unit |
| cmd_sec_wr | input | 1 | Command write to the secondary unit |
| cmd_byte | input | 8 | Command byte |
| int_pending | output | 1 | Unmasked request present |
| int_vector | output | 8 | Vector of the winner, valid while pending |
| req_prim | output | 8 | Primary request register |
| req_sec | output | 8 | Secondary request register |
| srv_prim | output | 8 | Primary in-service register |
| srv_sec | output | 8 | Secondary in-service register |

## Verification
The hardest state to reach is a cascaded acknowledge. It needs primary input 2 to be the winner: lines 0 and 1 must be idle or masked, and the secondary unit must hold an unmasked request. The stimulus strobes two secondary lines one after another, checks the secondary vector, and then acknowledges. It next masks the whole secondary unit and strobes a secondary line again. This forces a primary-only commit on input 2. A strobe that coincides with the acknowledge of its own line is driven in the same cycle to cover the collision case.

// File: rtl/irq_pair_pkg.sv
`timescale 1ns/1ps
package irq_pair_pkg;
    localparam int IN_W  = 8;
    localparam int IDX_W = $clog2(IN_W);
    localparam int VEC_W = 8;
    localparam int CMD_W = 8;

    // command byte layout: level, EOI flag, select flag, rotate flag
    localparam int LVL_LSB = 0;
    localparam int EOI_BIT = 5;
    localparam int SEL_BIT = 6;
    localparam int ROT_BIT = 7;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_EOI_NAMED,
        CMD_EOI_LOWEST,
        CMD_OTHER
    } cmd_kind_e;

    function automatic cmd_kind_e decode_cmd(input logic valid, input logic [CMD_W-1:0] c);
        if (!valid)
            return CMD_IDLE;
        if (c[EOI_BIT] && !c[ROT_BIT])
            return c[SEL_BIT] ? CMD_EOI_NAMED : CMD_EOI_LOWEST;
        return CMD_OTHER;
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [W-1:0]  first,
    output logic [IW-1:0] idx
);
    // one-hot of the lowest set bit, one slice per input
    for (genvar i = 0; i < W; i++) begin : g_first
        if (i == 0) begin : g_low
            assign first[i] = vec[i];
        end else begin : g_up
            assign first[i] = vec[i] & ~(|vec[i-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i])
                idx = idx | IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/irq_unit.sv
`timescale 1ns/1ps
module irq_unit
    import irq_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  req_set,
    input  logic [IN_W-1:0]  mask,
    input  logic             ack_take,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd,
    output logic             pend,
    output logic [IDX_W-1:0] win_idx,
    output logic [IN_W-1:0]  irr_q,
    output logic [IN_W-1:0]  isr_q
);
    logic [IN_W-1:0]  req_first;
    logic [IN_W-1:0]  isr_first;
    logic             isr_any;
    logic [IDX_W-1:0] isr_idx;
    logic [IN_W-1:0]  take_bit;
    logic [IN_W-1:0]  eoi_clr;
    logic [IDX_W-1:0] level;
    cmd_kind_e        kind;

    irq_prio_pick #(.W(IN_W)) u_req_pick (
        .vec   (irr_q & ~mask),
        .any   (pend),
        .first (req_first),
        .idx   (win_idx)
    );

    irq_prio_pick #(.W(IN_W)) u_isr_pick (
        .vec   (isr_q),
        .any   (isr_any),
        .first (isr_first),
        .idx   (isr_idx)
    );

    assign level    = cmd[LVL_LSB +: IDX_W];
    assign take_bit = ack_take ? req_first : '0;

    always_comb begin
        kind = decode_cmd(cmd_wr, cmd);
        unique case (kind)
            CMD_EOI_NAMED:  eoi_clr = IN_W'(1) << level;
            CMD_EOI_LOWEST: eoi_clr = isr_first;
            CMD_OTHER:      eoi_clr = '0;
            CMD_IDLE:       eoi_clr = '0;
        endcase
    end

    // new strobes win over the acknowledge clear; acknowledge set wins over EOI clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~take_bit) | req_set;
            isr_q <= (isr_q & ~eoi_clr) | take_bit;
        end
    end

    assert_request_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set) |=> ((irr_q & $past(req_set)) == $past(req_set)));

    assert_ack_sets_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> isr_q[$past(win_idx)]);

    assert_ack_clears_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !req_set[win_idx]) |=> !irr_q[$past(win_idx)]);

    assert_named_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_EOI_NAMED && !ack_take) |=> !isr_q[$past(level)]);

    assert_lowest_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_EOI_LOWEST && !ack_take) |=> (isr_q == ($past(isr_q) & ($past(isr_q) - IN_W'(1)))));

    assert_lowest_eoi_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_EOI_LOWEST && isr_any && !ack_take) |=> !isr_q[$past(isr_idx)]);

    assert_other_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_OTHER && !ack_take) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irq_pair_core.sv
`timescale 1ns/1ps
module irq_pair_core
    import irq_pair_pkg::*;
#(
    parameter int CASCADE_PIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*IN_W-1:0]  req_strobe,
    input  logic [IN_W-1:0]    mask_prim,
    input  logic [IN_W-1:0]    mask_sec,
    input  logic [VEC_W-1:0]   base_prim,
    input  logic [VEC_W-1:0]   base_sec,
    input  logic               ack,
    input  logic               cmd_prim_wr,
    input  logic               cmd_sec_wr,
    input  logic [CMD_W-1:0]   cmd_byte,
    output logic               int_pending,
    output logic [VEC_W-1:0]   int_vector,
    output logic [IN_W-1:0]    req_prim,
    output logic [IN_W-1:0]    req_sec,
    output logic [IN_W-1:0]    srv_prim,
    output logic [IN_W-1:0]    srv_sec
);
    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(CASCADE_PIN);
    localparam logic [IN_W-1:0]  LINK_BIT = IN_W'(1) << CASCADE_PIN;

    logic             sec_raise;
    logic [IN_W-1:0]  prim_set;
    logic             prim_pend;
    logic             sec_pend;
    logic [IDX_W-1:0] prim_win;
    logic [IDX_W-1:0] sec_win;
    logic             sec_route;
    logic             prim_take;
    logic             sec_take;

    assign sec_raise = |req_strobe[2*IN_W-1:IN_W];
    assign prim_set  = req_strobe[IN_W-1:0] | (sec_raise ? LINK_BIT : '0);
    assign sec_route = prim_pend && (prim_win == LINK_IDX) && sec_pend;
    assign prim_take = ack && prim_pend;
    assign sec_take  = ack && sec_route;

    irq_unit u_prim (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (prim_set),
        .mask     (mask_prim),
        .ack_take (prim_take),
        .cmd_wr   (cmd_prim_wr),
        .cmd      (cmd_byte),
        .pend     (prim_pend),
        .win_idx  (prim_win),
        .irr_q    (req_prim),
        .isr_q    (srv_prim)
    );

    irq_unit u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_strobe[2*IN_W-1:IN_W]),
        .mask     (mask_sec),
        .ack_take (sec_take),
        .cmd_wr   (cmd_sec_wr),
        .cmd      (cmd_byte),
        .pend     (sec_pend),
        .win_idx  (sec_win),
        .irr_q    (req_sec),
        .isr_q    (srv_sec)
    );

    assign int_pending = prim_pend;
    assign int_vector  = sec_route ? (base_sec + VEC_W'(sec_win))
                                   : (base_prim + VEC_W'(prim_win));

    assert_cascade_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_take |=> (srv_prim[CASCADE_PIN] && (|srv_sec)));

    assert_secondary_sets_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_raise |=> req_prim[CASCADE_PIN]);

    assert_idle_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_pending && !cmd_prim_wr) |=> (srv_prim == $past(srv_prim)));
endmodule

// File: tb/test_irq_pair_core.sv
`timescale 1ns/1ps
module test_irq_pair_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_strobe = '0;
    logic [7:0]  mask_prim = '0, mask_sec = '0;
    logic [7:0]  base_prim = 8'h20, base_sec = 8'h70;
    logic        ack = 1'b0, cmd_prim_wr = 1'b0, cmd_sec_wr = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        int_pending;
    logic [7:0]  int_vector, req_prim, req_sec, srv_prim, srv_sec;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // reference state
    logic [7:0] m_irr = '0, m_isr = '0, s_irr = '0, s_isr = '0;

    irq_pair_core i_irq_pair_core (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe),
        .mask_prim(mask_prim), .mask_sec(mask_sec),
        .base_prim(base_prim), .base_sec(base_sec), .ack(ack),
        .cmd_prim_wr(cmd_prim_wr), .cmd_sec_wr(cmd_sec_wr), .cmd_byte(cmd_byte),
        .int_pending(int_pending), .int_vector(int_vector),
        .req_prim(req_prim), .req_sec(req_sec), .srv_prim(srv_prim), .srv_sec(srv_sec)
    );

    always #10 clk = ~clk; // 50 MHz

    function automatic int low8(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] eoi_clear(logic [7:0] c, logic [7:0] isr);
        int k;
        if (!c[5] || c[7]) return 8'h00;
        if (c[6]) return 8'h01 << c[2:0];
        k = low8(isr);
        return (k < 0) ? 8'h00 : (8'h01 << k);
    endfunction

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        int mw, sw;
        logic [7:0] ev;
        mw = low8(m_irr & ~mask_prim);
        sw = low8(s_irr & ~mask_sec);
        chk("pending", {7'd0, int_pending}, {7'd0, mw >= 0});
        if (mw >= 0) begin
            if (mw == 2 && sw >= 0) ev = base_sec + 8'(sw);
            else ev = base_prim + 8'(mw);
            chk("vector", int_vector, ev);
        end
        chk("req_prim", req_prim, m_irr);
        chk("req_sec", req_sec, s_irr);
        chk("srv_prim", srv_prim, m_isr);
        chk("srv_sec", srv_sec, s_isr);
    endtask

    task automatic model_step();
        int mw, sw;
        logic [7:0] mt, st, mc, sc;
        mt = '0; st = '0;
        mw = low8(m_irr & ~mask_prim);
        sw = low8(s_irr & ~mask_sec);
        if (ack && mw >= 0) begin
            mt[mw] = 1'b1;
            if (mw == 2 && sw >= 0) st[sw] = 1'b1;
        end
        mc = cmd_prim_wr ? eoi_clear(cmd_byte, m_isr) : 8'h00;
        sc = cmd_sec_wr ? eoi_clear(cmd_byte, s_isr) : 8'h00;
        m_irr = (m_irr & ~mt) | req_strobe[7:0] | ((|req_strobe[15:8]) ? 8'h04 : 8'h00);
        s_irr = (s_irr & ~st) | req_strobe[15:8];
        m_isr = (m_isr & ~mc) | mt;
        s_isr = (s_isr & ~sc) | st;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #5;
        compare();
    endtask

    task automatic strobe(logic [15:0] r);
        req_strobe = r; tick(); req_strobe = '0;
    endtask
    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask
    task automatic cmd_p(logic [7:0] c);
        cmd_byte = c; cmd_prim_wr = 1'b1; tick(); cmd_prim_wr = 1'b0;
    endtask
    task automatic cmd_s(logic [7:0] c);
        cmd_byte = c; cmd_sec_wr = 1'b1; tick(); cmd_sec_wr = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        tag = "R1"; compare();                       // reset state

        tag = "R2"; strobe(16'h0020); strobe(16'h0008);
        tag = "R4"; strobe(16'h0001);
        base_prim = 8'hFE; tick();                   // wraps to 0xFE
        tag = "R3"; mask_prim = 8'h09; tick();       // 0xFE+5 -> 0x03
        mask_prim = 8'hFF; tick();                   // nothing pending, bits kept
        mask_prim = 8'h00; base_prim = 8'h20; tick();

        tag = "R5"; do_ack(); do_ack();              // service 0 then 3
        mask_prim = 8'hFF; do_ack();                 // ignored
        mask_prim = 8'h00; tick();

        tag = "R9"; cmd_p(8'h00); cmd_p(8'hA0); cmd_p(8'hE3); cmd_p(8'h40);
        tag = "R5"; do_ack();                        // service 5
        tag = "R7"; cmd_p(8'h63); cmd_p(8'h66);
        tag = "R8"; cmd_p(8'h20); cmd_p(8'h20); cmd_p(8'h20);

        tag = "R6"; strobe(16'h1000); strobe(16'h0200);
        do_ack();
        strobe(16'h0100); do_ack();
        cmd_s(8'h61); cmd_s(8'h20); cmd_p(8'h62);
        tag = "R2"; strobe(16'h8181);

        tag = "R11"; mask_prim = 8'h03; mask_sec = 8'hFF; strobe(16'h4000);
        do_ack();
        mask_sec = 8'h00; mask_prim = 8'h00; tick();

        tag = "R10"; mask_prim = 8'h3F; strobe(16'h0040);
        req_strobe = 16'h0040; ack = 1'b1; tick();
        req_strobe = '0; ack = 1'b0; tick();
        mask_prim = 8'h00; tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule